// File: doc/BRIEF.md
# Alarm-Started Periodic Pulse Generator

This block drives three periodic pulse lines whose timing follows a free-running 64-bit time value. Each channel has a 32-bit interval count that is decremented by the integer clock period on every timer clock. When the remaining count can no longer absorb one more period step, the channel emits a pulse and reloads. The output pulse is stretched to a programmed number of output-clock cycles. That output clock is the timer clock divided by an even prescaler. Each channel has its own polarity bit and disable bit.

Two 64-bit alarm comparators fire when the time value reaches their programmed value. The first alarm can also act as a start gate. In start-synchronised mode the interval counters stay held at their reload value until the first alarm fires. The counters then begin counting on the next clock. Pulse and alarm occurrences set sticky event bits, which software clears by writing one to them. The interrupt line is raised while any event bit is set and its mask bit is also set.

Software reaches the block through a simple word-addressed register bus. A write takes effect on the clock edge that samples it. A read returns combinationally the register selected by the read address.

Top module: `alarm_pulse_gen`

## Requirements
- R1: After reset the pulse outputs are low, `irq` is low and the event and mask registers read 0. The prescaler reads 2, both alarms and all three interval registers read all-ones, and the channel control word reads 0x00808080 (all channels disabled).
- R2: Word addresses are fixed. Control is at 0 (bit 0 = start-synchronised), events at 1, mask at 2, alarm 1 low/high at 3/4, alarm 2 low/high at 5/6, prescaler at 7, interval n at 8+n and channel control at 11. Channel n uses byte n of the channel control word: width at bits 4:0, polarity at bit 6, disable at bit 7.
- R3: Let the clock period be P and the interval be (k-1)·P, with the channel enabled and free-running. The first pulse begins on the k-th clock edge after the edge that enables the channel, and later pulses follow every k clocks. The terminal condition is a remaining count smaller than P.
- R4: A pulse stays active for width × prescaler timer clocks. A width of 0 produces no output pulse, but the event is still recorded.
- R5: A prescaler write is stored in legal form. An odd value is rounded up to the next even value, 0xFFFF becomes 0xFFFE, and 0 becomes 2.
- R6: An interval of all-ones marks the channel idle. An idle channel produces no pulse and no event.
- R7: Setting a channel's disable bit drives its output to the inactive level on the same edge and ends any pulse in progress. It also reloads the counter, so the first pulse after re-enabling comes a full k clocks later.
- R8: With polarity bit 6 set, a channel is active low. Its inactive level, including while disabled, is high.
- R9: An alarm fires in the first cycle in which the time value is greater than or equal to its programmed value. It then returns to all-ones and fires only once. An all-ones alarm never fires. A low-word write is only staged, and the alarm changes when the high word is written.
- R10: In start-synchronised mode the channel counters are held until alarm 1 fires. Alarm 2 does not release them. Any write to the control register re-arms the hold.
- R11: Event bits are set by channel n at bit 7-n, alarm 1 at bit 16 and alarm 2 at bit 17. Writing a one clears a bit, and a new event in the same cycle wins over the clear.
- R12: `irq` is high exactly while some event bit and its mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_now | input | 64 | Running time value |
| clk_period | input | 10 | Integer clock period, the step of each interval counter |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Write word address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 4 | Read word address |
| reg_rdata | output | 32 | Read data, combinational from the read address |
| pulse_out | output | 3 | Pulse lines, one per channel |
| irq | output | 1 | Masked event interrupt |

## Verification
A register write lands on the edge that samples it. Readback, `irq` and the disable gating are visible at the falling edge right after that edge. The bench drives every write at a falling edge and samples one falling edge later. A channel enabled by a write shows its first pulse at the k+1-th falling edge after that write's falling edge. The bench counts falling edges from the write and compares the first-rise, second-rise and pulse-length positions with those exact numbers. Alarm-started behaviour depends on the moving time value. For that case the bench checks that no pulse appears before the alarm is armed and that the first pulse appears with the time already at or past the alarm value.

// File: rtl/apg_pkg.sv
// Package: shared sizes, register word addresses and helpers for the
// alarm-started pulse generator. Assumes TIME_W == 2 * DATA_W.
package apg_pkg;
    localparam int NCH      = 3;   // pulse channels (at most 8: event bit 7-n)
    localparam int NALM     = 2;   // alarm comparators
    localparam int TIME_W   = 64;
    localparam int DATA_W   = 32;
    localparam int IVL_W    = 32;
    localparam int PER_W    = 10;
    localparam int PSC_W    = 16;
    localparam int WID_W    = 5;
    localparam int ADDR_W   = 4;

    localparam int EV_PULSE_TOP = 7;
    localparam int EV_ALM_BASE  = 16;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_EVENT  = 4'd1;
    localparam logic [ADDR_W-1:0] A_MASK   = 4'd2;
    localparam logic [ADDR_W-1:0] A_ALM_LO = 4'd3;  // alarm a low at 3+2a
    localparam logic [ADDR_W-1:0] A_PRESC  = 4'd7;
    localparam logic [ADDR_W-1:0] A_IVL0   = 4'd8;  // interval n at 8+n
    localparam logic [ADDR_W-1:0] A_CHCTL  = 4'd11;

    localparam logic [PSC_W-1:0] PSC_RESET = 16'd2;
    localparam logic [PSC_W-1:0] PSC_MAX   = 16'hFFFE;

    typedef struct packed {
        logic             dis;
        logic             pol;
        logic [WID_W-1:0] width;
    } ch_cfg_t;

    // Set of event bits that hardware can raise.
    function automatic logic [DATA_W-1:0] ev_impl_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int n = 0; n < NCH; n++) m[EV_PULSE_TOP-n] = 1'b1;
        for (int a = 0; a < NALM; a++) m[EV_ALM_BASE+a] = 1'b1;
        return m;
    endfunction

    // Bring a requested prescaler into legal (even, non-zero, capped) form.
    function automatic logic [PSC_W-1:0] legal_psc(input logic [PSC_W-1:0] v);
        if (v == '0)            return PSC_RESET;
        else if (v >= PSC_MAX)  return PSC_MAX;
        else                    return v + {{(PSC_W-1){1'b0}}, v[0]};
    endfunction
endpackage

// File: rtl/apg_alarm.sv
// Module: one 64-bit alarm comparator. A low-word write is staged and the
// full value commits with the high-word write. The alarm fires while the
// time is at or past the value, then disarms itself to all-ones.
// Assumes the time value never wraps within an armed window.
module apg_alarm
    import apg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic [TIME_W-1:0] time_now,
    output logic              fire,
    output logic [TIME_W-1:0] value
);
    logic [DATA_W-1:0] lo_stage;
    logic [TIME_W-1:0] alarm_q;

    // Compare: an all-ones value means disarmed.
    always_comb fire = (alarm_q != '1) && (time_now >= alarm_q);

    // Staging, commit on high write, one-shot disarm after firing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_stage <= '0;
            alarm_q  <= '1;
        end else begin
            if (wr_lo) lo_stage <= wdata;
            if (wr_hi)     alarm_q <= {wdata, lo_stage};
            else if (fire) alarm_q <= '1;
        end
    end

    assign value = alarm_q;

    a_r9_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !wr_hi) |=> (value == '1));
endmodule

// File: rtl/apg_channel.sv
// Module: one interval channel. A down-counter steps by the clock period.
// When the remaining count is below one period, the channel emits a pulse
// and reloads. The pulse is stretched for width x prescaler clocks.
// Assumes the prescaler input is already legal (even, >= 2).
module apg_channel
    import apg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [IVL_W-1:0] interval,
    input  logic [PER_W-1:0] period,
    input  logic [PSC_W-1:0] prescale,
    input  ch_cfg_t          cfg,
    output logic             fire,
    output logic             pulse
);
    localparam logic [PSC_W-1:0] PSC_ONE = PSC_W'(1);
    localparam logic [WID_W-1:0] WID_ONE = WID_W'(1);

    logic [IVL_W-1:0] cnt;
    logic [IVL_W-1:0] step;
    logic             idle;
    logic             terminal;
    logic             active;
    logic [WID_W-1:0] wcnt;
    logic [PSC_W-1:0] pcnt;

    // Terminal decode and fire qualification.
    always_comb begin
        step     = {{(IVL_W-PER_W){1'b0}}, period};
        idle     = &interval;
        terminal = cnt < step;
        fire     = run && !cfg.dis && !idle && terminal;
    end

    // Interval counter: held at reload while stopped, else step down.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt <= '1;
        else if (cfg.dis || idle || !run)    cnt <= interval;
        else if (terminal)                   cnt <= interval;
        else                                 cnt <= cnt - step;
    end

    // Pulse stretcher in units of prescaled output-clock cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            wcnt   <= '0;
            pcnt   <= '0;
        end else if (cfg.dis) begin
            active <= 1'b0;
            wcnt   <= '0;
            pcnt   <= '0;
        end else if (fire) begin
            active <= (cfg.width != '0);
            wcnt   <= cfg.width;
            pcnt   <= '0;
        end else if (active) begin
            if (pcnt == prescale - PSC_ONE) begin
                pcnt <= '0;
                wcnt <= wcnt - WID_ONE;
                if (wcnt == WID_ONE) active <= 1'b0;
            end else begin
                pcnt <= pcnt + PSC_ONE;
            end
        end
    end

    // Output: disable gates at once, polarity selects the active level.
    always_comb pulse = (active && !cfg.dis) ^ cfg.pol;

    a_r7_dis_ends: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.dis |=> !active);
    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cnt == $past(interval)));
    a_r4_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cfg.width == '0) |=> !active);
endmodule

// File: rtl/apg_regs.sv
// Module: register file. Holds control, event, mask, prescaler, interval
// and channel control registers, plus the start-release flag. Provides the
// combinational readback mux and the interrupt. Assumes single-word writes.
module apg_regs
    import apg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NALM-1:0]   alm_fire,
    input  logic [TIME_W-1:0] alm_val [NALM],
    input  logic [NCH-1:0]    ch_fire,
    output logic [NALM-1:0]   alm_wr_lo,
    output logic [NALM-1:0]   alm_wr_hi,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              run,
    output logic [PSC_W-1:0]  prescale,
    output logic [IVL_W-1:0]  interval [NCH],
    output ch_cfg_t           cfg [NCH]
);
    localparam logic [DATA_W-1:0] EV_IMPL = ev_impl_mask();

    logic              sync_q;
    logic              released;
    logic [DATA_W-1:0] event_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] ev_set;
    logic [DATA_W-1:0] ev_clr;
    logic              wr_ctrl, wr_event, wr_mask, wr_presc, wr_chctl;

    // Write strobe decode.
    always_comb begin
        wr_ctrl  = wr_en && (wr_addr == A_CTRL);
        wr_event = wr_en && (wr_addr == A_EVENT);
        wr_mask  = wr_en && (wr_addr == A_MASK);
        wr_presc = wr_en && (wr_addr == A_PRESC);
        wr_chctl = wr_en && (wr_addr == A_CHCTL);
    end

    // Alarm strobes: alarm a occupies words 3+2a (low) and 4+2a (high).
    for (genvar a = 0; a < NALM; a++) begin : g_alm_dec
        localparam logic [ADDR_W-1:0] LO = A_ALM_LO + ADDR_W'(2 * a);
        assign alm_wr_lo[a] = wr_en && (wr_addr == LO);
        assign alm_wr_hi[a] = wr_en && (wr_addr == LO + ADDR_W'(1));
    end

    // Event set and clear vectors.
    always_comb begin
        ev_set = '0;
        for (int n = 0; n < NCH; n++) ev_set[EV_PULSE_TOP-n] = ch_fire[n];
        for (int a = 0; a < NALM; a++) ev_set[EV_ALM_BASE+a] = alm_fire[a];
        ev_clr = wr_event ? (wr_data & EV_IMPL) : '0;
    end

    // Control, release flag, event, mask and prescaler registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q   <= 1'b0;
            released <= 1'b0;
            event_q  <= '0;
            mask_q   <= '0;
            prescale <= PSC_RESET;
        end else begin
            if (wr_ctrl) begin
                sync_q   <= wr_data[0];
                released <= 1'b0;
            end else if (alm_fire[0]) begin
                released <= 1'b1;
            end
            event_q <= (event_q & ~ev_clr) | ev_set;
            if (wr_mask)  mask_q   <= wr_data & EV_IMPL;
            if (wr_presc) prescale <= legal_psc(wr_data[PSC_W-1:0]);
        end
    end

    // Interval and per-channel control bytes.
    for (genvar n = 0; n < NCH; n++) begin : g_ch_regs
        localparam logic [ADDR_W-1:0] IA = A_IVL0 + ADDR_W'(n);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                interval[n] <= '1;
                cfg[n]      <= '{dis: 1'b1, pol: 1'b0, width: '0};
            end else begin
                if (wr_en && wr_addr == IA) interval[n] <= wr_data[IVL_W-1:0];
                if (wr_chctl) begin
                    cfg[n].width <= wr_data[8*n +: WID_W];
                    cfg[n].pol   <= wr_data[8*n + 6];
                    cfg[n].dis   <= wr_data[8*n + 7];
                end
            end
        end
    end

    // Counter gate and interrupt.
    always_comb begin
        run = !sync_q || released;
        irq = |(event_q & mask_q);
    end

    // Combinational readback.
    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL)       rd_data[0] = sync_q;
        else if (rd_addr == A_EVENT) rd_data = event_q;
        else if (rd_addr == A_MASK)  rd_data = mask_q;
        else if (rd_addr == A_PRESC) rd_data[PSC_W-1:0] = prescale;
        else if (rd_addr == A_CHCTL) begin
            for (int n = 0; n < NCH; n++)
                rd_data[8*n +: 8] = {cfg[n].dis, cfg[n].pol, 1'b0, cfg[n].width};
        end else begin
            for (int a = 0; a < NALM; a++) begin
                if (rd_addr == A_ALM_LO + ADDR_W'(2 * a))
                    rd_data = alm_val[a][DATA_W-1:0];
                if (rd_addr == A_ALM_LO + ADDR_W'(2 * a + 1))
                    rd_data = alm_val[a][TIME_W-1:DATA_W];
            end
            for (int n = 0; n < NCH; n++)
                if (rd_addr == A_IVL0 + ADDR_W'(n)) rd_data = interval[n];
        end
    end

    a_r11_w1c_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_event && wr_data[EV_ALM_BASE] && !alm_fire[0]) |=> !event_q[EV_ALM_BASE]);
    a_r10_ctrl_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wr_data[0]) |=> !run);
endmodule

// File: rtl/alarm_pulse_gen.sv
// Module: top of the alarm-started pulse generator. Ties the register
// file to two alarm comparators and the interval channels.
// Assumes time_now advances by clk_period per clock when running.
module alarm_pulse_gen
    import apg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] time_now,
    input  logic [PER_W-1:0]  clk_period,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NCH-1:0]    pulse_out,
    output logic              irq
);
    logic [NALM-1:0]   alm_fire, alm_wr_lo, alm_wr_hi;
    logic [TIME_W-1:0] alm_val [NALM];
    logic [NCH-1:0]    ch_fire;
    logic              run;
    logic [PSC_W-1:0]  prescale;
    logic [IVL_W-1:0]  interval [NCH];
    ch_cfg_t           cfg [NCH];

    apg_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .rd_addr(reg_raddr),
        .alm_fire(alm_fire), .alm_val(alm_val), .ch_fire(ch_fire),
        .alm_wr_lo(alm_wr_lo), .alm_wr_hi(alm_wr_hi),
        .rd_data(reg_rdata), .irq(irq), .run(run),
        .prescale(prescale), .interval(interval), .cfg(cfg)
    );

    for (genvar a = 0; a < NALM; a++) begin : g_alarm
        apg_alarm u_alarm (
            .clk(clk), .rst_n(rst_n),
            .wr_lo(alm_wr_lo[a]), .wr_hi(alm_wr_hi[a]), .wdata(reg_wdata),
            .time_now(time_now),
            .fire(alm_fire[a]), .value(alm_val[a])
        );
    end

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        apg_channel u_chan (
            .clk(clk), .rst_n(rst_n), .run(run),
            .interval(interval[n]), .period(clk_period), .prescale(prescale),
            .cfg(cfg[n]), .fire(ch_fire[n]), .pulse(pulse_out[n])
        );
    end
endmodule

// File: tb/alarm_pulse_gen_tb.sv
module alarm_pulse_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_now = '0;
    logic [9:0]  clk_period = 10'd1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  pulse_out;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    // Table: period, cycles per pulse k, width, prescaler.
    localparam int NV = 4;
    localparam int V_P  [NV] = '{1, 4, 3, 8};
    localparam int V_K  [NV] = '{10, 8, 20, 6};
    localparam int V_W  [NV] = '{2, 1, 3, 1};
    localparam int V_PR [NV] = '{2, 4, 6, 2};

    alarm_pulse_gen u_dut (
        .clk(clk), .rst_n(rst_n), .time_now(time_now), .clk_period(clk_period),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .pulse_out(pulse_out), .irq(irq)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) time_now <= '0;
        else        time_now <= time_now + {54'd0, clk_period};
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    // Sample at falling edges from the current one: first rise, second
    // rise and length of the first pulse, all counted from 1.
    task automatic watch(input int ch, input bit lvl, input int ncyc,
                         output int r1, output int r2, output int hl);
        bit prev;
        bit first_done;
        r1 = 0; r2 = 0; hl = 0; prev = 1'b0; first_done = 1'b0;
        for (int n = 1; n <= ncyc; n++) begin
            bit a;
            a = (pulse_out[ch] == lvl);
            if (a && !prev) begin
                if (r1 == 0) r1 = n;
                else if (r2 == 0) r2 = n;
            end
            if (r1 != 0 && !first_done) begin
                if (a) hl++;
                else first_done = 1'b1;
            end
            prev = a;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [63:0] t;
        int r1, r2, hl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pulse_out", {61'd0, pulse_out}, 64'd0);
        chk("R1 irq", {63'd0, irq}, 64'd0);
        rd(4'd1, d);  chk("R1 event", {32'd0, d}, 64'd0);
        rd(4'd7, d);  chk("R1 prescaler", {32'd0, d}, 64'd2);
        rd(4'd3, d);  chk("R1 alarm1 low", {32'd0, d}, 64'hFFFF_FFFF);
        rd(4'd8, d);  chk("R1 interval0", {32'd0, d}, 64'hFFFF_FFFF);
        rd(4'd11, d); chk("R2 chctl reset", {32'd0, d}, 64'h0080_8080);

        // R3/R4 table of interval and width vectors on channel 0
        for (int v = 0; v < NV; v++) begin
            wr(4'd11, 32'h0080_8080);
            clk_period = 10'(V_P[v]);
            wr(4'd7, 32'(V_PR[v]));
            wr(4'd8, 32'((V_K[v] - 1) * V_P[v]));
            wr(4'd11, 32'h0080_8000 | 32'(V_W[v]));
            watch(0, 1'b1, 3 * V_K[v] + 5, r1, r2, hl);
            chk($sformatf("R3 first rise v%0d", v), 64'(r1), 64'(V_K[v] + 1));
            chk($sformatf("R3 second rise v%0d", v), 64'(r2), 64'(2 * V_K[v] + 1));
            chk($sformatf("R4 width v%0d", v), 64'(hl), 64'(V_W[v] * V_PR[v]));
        end
        wr(4'd11, 32'h0080_8080);

        // R5 prescaler legalisation
        wr(4'd7, 32'd5);      rd(4'd7, d); chk("R5 odd rounds up", {32'd0, d}, 64'd6);
        wr(4'd7, 32'hFFFF);   rd(4'd7, d); chk("R5 cap", {32'd0, d}, 64'hFFFE);
        wr(4'd7, 32'd0);      rd(4'd7, d); chk("R5 zero", {32'd0, d}, 64'd2);

        // R11/R12 event bit 7 for channel 0, mask, write-one-to-clear
        rd(4'd1, d); chk("R11 ch0 event bit7", {32'd0, d}, 64'h80);
        chk("R12 irq masked off", {63'd0, irq}, 64'd0);
        wr(4'd2, 32'h80);
        chk("R12 irq on", {63'd0, irq}, 64'd1);
        wr(4'd1, 32'h80);
        rd(4'd1, d); chk("R11 w1c clears", {32'd0, d}, 64'd0);
        chk("R12 irq off after clear", {63'd0, irq}, 64'd0);

        // R4 zero width: event but no output
        clk_period = 10'd1;
        wr(4'd8, 32'd4);
        wr(4'd11, 32'h0080_8000);
        watch(0, 1'b1, 15, r1, r2, hl);
        chk("R4 zero width silent", 64'(r1), 64'd0);
        wr(4'd11, 32'h0080_8080);
        rd(4'd1, d); chk("R4 zero width event", {32'd0, d}, 64'h80);
        wr(4'd1, 32'hFFFF_FFFF);

        // R6 idle channel 1 (interval still all-ones)
        wr(4'd11, 32'h0080_0180);
        watch(1, 1'b1, 40, r1, r2, hl);
        chk("R6 idle no pulse", 64'(r1), 64'd0);
        rd(4'd1, d); chk("R6 idle no event", {32'd0, d}, 64'd0);
        wr(4'd11, 32'h0080_8080);

        // R8 polarity on channel 2
        wr(4'd11, 32'h00C1_8080);
        chk("R8 disabled inverted idle high", {63'd0, pulse_out[2]}, 64'd1);
        wr(4'd10, 32'd5);
        wr(4'd11, 32'h0041_8080);
        watch(2, 1'b0, 20, r1, r2, hl);
        chk("R8 active-low first fall", 64'(r1), 64'd7);
        chk("R8 active-low length", 64'(hl), 64'd2);
        wr(4'd11, 32'h00C1_8080);
        rd(4'd1, d); chk("R11 ch2 event bit5", {32'd0, d & 32'h20}, 64'h20);

        // R7 disable mid-pulse, then reload on re-enable
        wr(4'd10, 32'd19);
        wr(4'd11, 32'h0044_8080);
        for (int n = 0; n < 40 && pulse_out[2] != 1'b0; n++) @(negedge clk);
        wr(4'd11, 32'h00C4_8080);
        chk("R7 disable ends pulse", {63'd0, pulse_out[2]}, 64'd1);
        wr(4'd11, 32'h0044_8080);
        watch(2, 1'b0, 30, r1, r2, hl);
        chk("R7 reload after re-enable", 64'(r1), 64'd21);
        wr(4'd11, 32'h00C4_8080);
        wr(4'd1, 32'hFFFF_FFFF);

        // R10/R9 start-synchronised on channel 0, released by alarm 1
        clk_period = 10'd2;
        wr(4'd8, 32'd8);
        wr(4'd0, 32'd1);
        wr(4'd11, 32'h00C4_8001);
        watch(0, 1'b1, 30, r1, r2, hl);
        chk("R10 held before alarm", 64'(r1), 64'd0);
        t = time_now + 64'd100;
        wr(4'd3, t[31:0]);
        rd(4'd3, d); chk("R9 low write only staged", {32'd0, d}, 64'hFFFF_FFFF);
        wr(4'd4, t[63:32]);
        rd(4'd3, d); chk("R9 committed low", {32'd0, d}, {32'd0, t[31:0]});
        r1 = 0;
        for (int n = 0; n < 300 && r1 == 0; n++) begin
            if (pulse_out[0]) r1 = 1;
            else @(negedge clk);
        end
        chk("R10 pulse after alarm", 64'(r1), 64'd1);
        chk("R9 fires at or past value", {63'd0, time_now >= t}, 64'd1);
        rd(4'd4, d); chk("R9 one-shot disarm", {32'd0, d}, 64'hFFFF_FFFF);
        rd(4'd1, d); chk("R11 alarm1 bit16", {32'd0, d & 32'h1_0000}, 64'h1_0000);

        // R10 re-arm; alarm 2 does not release the counters
        wr(4'd0, 32'd1);
        repeat (4) @(negedge clk);
        t = time_now + 64'd20;
        wr(4'd5, t[31:0]);
        wr(4'd6, t[63:32]);
        watch(0, 1'b1, 40, r1, r2, hl);
        chk("R10 alarm2 does not release", 64'(r1), 64'd0);
        rd(4'd1, d); chk("R11 alarm2 bit17", {32'd0, d & 32'h2_0000}, 64'h2_0000);
        rd(4'd6, d); chk("R9 alarm2 one-shot", {32'd0, d}, 64'hFFFF_FFFF);

        finish_run();
    end
endmodule